// File: doc/BRIEF.md
# Four-Stack Shared-TOS Execution Core

This block is the execution core of a small stack machine. It has one top-of-stack (TOS) register and four independent data stacks, A to D, below it. Every primitive carries a 2-bit selector that names the stack it pushes to, reads from or pops. The second operand of an arithmetic or compare primitive comes from the top of that stack. The operation and the selector form a 7-bit instruction word. Jumps carry a short signed offset and calls carry a full target address. The core presents a new program counter every cycle.

The fetch logic delivers at most one instruction per cycle on `instrValid`, taken from the address shown on `pc`. Each stack has its own sticky overflow and underflow flag. An instruction that would overflow or underflow its stack changes neither the stacks nor TOS and falls through to the next address. Instruction memory, the return stack and subroutine bodies belong to other blocks.

Top module: `fourStackCore`

## Requirements
- R1: After reset `pc` is 0, `tos` is 0, all four stacks are empty and all error flags are clear.
- R2: Opcode 1 (dup) pushes a copy of TOS onto the selected stack (selector 0=A, 1=B, 2=C, 3=D) and leaves TOS unchanged.
- R3: Opcode 2 (over) copies the top of the selected stack into TOS and leaves that stack unchanged.
- R4: Opcode 3 (drop) discards TOS and pops the top of the selected stack into TOS.
- R5: Opcode 4 (add) sets TOS to top+TOS and opcode 5 (sub) sets TOS to top−TOS, modulo 2^DATA_W, where top is the top of the selected stack. Both pop that stack.
- R6: Opcode 6 (inc) adds 1 to TOS and opcode 7 (dec) subtracts 1 from TOS. Both ignore the selector and leave all stacks unchanged.
- R7: Opcode 8 (gt) and opcode 10 (le) compare top against TOS as signed values and pop the selected stack. Opcode 9 (gtz) tests TOS > 0 signed and pops nothing. Each writes all-ones to TOS for true and zero for false.
- R8: Opcode 11 (jz) ignores the selector and pops stack A into TOS. If TOS was zero before the instruction, `pc` becomes pc+1+offset, with offset a signed 5-bit value. Otherwise `pc` becomes pc+1.
- R9: Opcode 12 (jmp) sets `pc` to pc+1+offset (offset signed 5-bit). Opcode 13 (call) sets `pc` to `target`. Neither changes TOS or the stacks.
- R10: A push onto a stack that already holds DEPTH entries sets that stack's bit of `ovfErr` until reset. It leaves the stacks and TOS unchanged, and `pc` advances by 1.
- R11: A read or pop of an empty stack (over, drop, add, sub, gt, le on the selected stack, or jz on A) sets that stack's bit of `unfErr` until reset. It leaves the stacks and TOS unchanged, and `pc` advances by 1 without branching.
- R12: A cycle with `instrValid` low changes nothing.
- R13: Opcode 0 and opcodes 14 to 31 change no data state and advance `pc` by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | An instruction is present this cycle |
| opcode | input | 5 | Operation code |
| stackSel | input | 2 | Stack selector, 0=A to 3=D |
| offset | input | OFF_W | Signed jump offset |
| target | input | PC_W | Call target address |
| pc | output | PC_W | Program counter |
| tos | output | DATA_W | Top-of-stack register |
| ovfErr | output | 4 | Sticky overflow flag for each stack, bit 0 = A |
| unfErr | output | 4 | Sticky underflow flag for each stack, bit 0 = A |

## Verification
The bench builds the core with its default parameters: a 16-bit datapath, 16-bit program counter, 5-bit offsets and a stack depth of 8. With a depth of 8, a stack reaches overflow after nine pushes, so both full-stack and empty-stack faults occur often in directed and random streams. The 16-bit width makes carry wrap and the signed compare boundaries easy to reach. A 5-bit offset lets the full range of forward and backward branches, from −16 to +15, appear in a short run.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int NUM_STACKS = 4;

  localparam logic [4:0] OP_NOP  = 5'd0;
  localparam logic [4:0] OP_DUP  = 5'd1;
  localparam logic [4:0] OP_OVER = 5'd2;
  localparam logic [4:0] OP_DROP = 5'd3;
  localparam logic [4:0] OP_ADD  = 5'd4;
  localparam logic [4:0] OP_SUB  = 5'd5;
  localparam logic [4:0] OP_INC  = 5'd6;
  localparam logic [4:0] OP_DEC  = 5'd7;
  localparam logic [4:0] OP_GT   = 5'd8;
  localparam logic [4:0] OP_GTZ  = 5'd9;
  localparam logic [4:0] OP_LE   = 5'd10;
  localparam logic [4:0] OP_JZ   = 5'd11;
  localparam logic [4:0] OP_JMP  = 5'd12;
  localparam logic [4:0] OP_CALL = 5'd13;

  typedef enum logic [1:0] {
    TOS_KEEP  = 2'd0,
    TOS_STACK = 2'd1,
    TOS_ALU   = 2'd2
  } tos_src_e;

  typedef struct packed {
    logic       push;
    logic       pop;
    logic [1:0] sel;
    tos_src_e   tosSrc;
    logic [4:0] aluOp;
  } strobe_t;
endpackage

// File: rtl/fscStack.sv
module fscStack #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] topIdx;

  assign wrIdx  = IDX_W'(cnt);
  assign topIdx = IDX_W'(cnt - 1'b1);
  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign top    = empty ? '0 : mem[topIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[wrIdx] <= din;
    end
  end
endmodule

// File: rtl/fscDatapath.sv
module fscDatapath
  import fsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  output logic [DATA_W-1:0]     tos,
  output logic [NUM_STACKS-1:0] full,
  output logic [NUM_STACKS-1:0] empty
);
  logic [DATA_W-1:0] tops [NUM_STACKS];
  logic [DATA_W-1:0] topSel;
  logic [DATA_W-1:0] aluOut;
  logic [DATA_W-1:0] tosNext;

  for (genvar g = 0; g < NUM_STACKS; g++) begin : gStack
    fscStack #(.W(DATA_W), .DEPTH(DEPTH)) uStack (
      .clk   (clk),
      .rstN  (rstN),
      .push  (stb.push && (stb.sel == 2'(g))),
      .pop   (stb.pop  && (stb.sel == 2'(g))),
      .din   (tos),
      .top   (tops[g]),
      .full  (full[g]),
      .empty (empty[g])
    );
  end

  assign topSel = tops[stb.sel];

  always_comb begin
    aluOut = tos;
    case (stb.aluOp)
      OP_ADD:  aluOut = topSel + tos;
      OP_SUB:  aluOut = topSel - tos;
      OP_INC:  aluOut = tos + 1'b1;
      OP_DEC:  aluOut = tos - 1'b1;
      OP_GT:   aluOut = ($signed(topSel) >  $signed(tos)) ? '1 : '0;
      OP_LE:   aluOut = ($signed(topSel) <= $signed(tos)) ? '1 : '0;
      OP_GTZ:  aluOut = ($signed(tos) > 0) ? '1 : '0;
      default: aluOut = tos;
    endcase
  end

  always_comb begin
    case (stb.tosSrc)
      TOS_STACK: tosNext = topSel;
      TOS_ALU:   tosNext = aluOut;
      default:   tosNext = tos;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) tos <= '0;
    else       tos <= tosNext;
  end
endmodule

// File: rtl/fscControl.sv
module fscControl
  import fsc_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  instrValid,
  input  logic [4:0]            opcode,
  input  logic [1:0]            stackSel,
  input  logic [OFF_W-1:0]      offset,
  input  logic [PC_W-1:0]       target,
  input  logic                  tosZero,
  input  logic [NUM_STACKS-1:0] full,
  input  logic [NUM_STACKS-1:0] empty,
  output strobe_t               stb,
  output logic [PC_W-1:0]       pc,
  output logic [NUM_STACKS-1:0] ovfErr,
  output logic [NUM_STACKS-1:0] unfErr
);
  logic [1:0]      effSel;
  logic            isPush, isRead, isPop, fromStack, toAlu;
  logic            ovfHit, unfHit, fault;
  logic [PC_W-1:0] pcInc, pcRel, pcNext;

  assign effSel = (opcode == OP_JZ) ? 2'd0 : stackSel;

  always_comb begin
    isPush = 1'b0; isRead = 1'b0; isPop = 1'b0;
    fromStack = 1'b0; toAlu = 1'b0;
    case (opcode)
      OP_DUP:  isPush = 1'b1;
      OP_OVER: begin isRead = 1'b1; fromStack = 1'b1; end
      OP_DROP, OP_JZ: begin isRead = 1'b1; isPop = 1'b1; fromStack = 1'b1; end
      OP_ADD, OP_SUB, OP_GT, OP_LE: begin isRead = 1'b1; isPop = 1'b1; toAlu = 1'b1; end
      OP_INC, OP_DEC, OP_GTZ: toAlu = 1'b1;
      default: ;
    endcase
  end

  assign ovfHit = instrValid && isPush && full[effSel];
  assign unfHit = instrValid && isRead && empty[effSel];
  assign fault  = ovfHit || unfHit;

  always_comb begin
    stb.push   = instrValid && isPush && !fault;
    stb.pop    = instrValid && isPop && !fault;
    stb.sel    = effSel;
    stb.aluOp  = opcode;
    stb.tosSrc = TOS_KEEP;
    if (instrValid && !fault) begin
      if (fromStack)  stb.tosSrc = TOS_STACK;
      else if (toAlu) stb.tosSrc = TOS_ALU;
    end
  end

  assign pcInc = pc + 1'b1;
  assign pcRel = pcInc + {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};

  always_comb begin
    pcNext = pc;
    if (instrValid) begin
      pcNext = pcInc;
      if (!fault) begin
        case (opcode)
          OP_JZ:   if (tosZero) pcNext = pcRel;
          OP_JMP:  pcNext = pcRel;
          OP_CALL: pcNext = target;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      ovfErr <= '0;
      unfErr <= '0;
    end else begin
      pc <= pcNext;
      if (ovfHit) ovfErr[effSel] <= 1'b1;
      if (unfHit) unfErr[effSel] <= 1'b1;
    end
  end
endmodule

// File: rtl/fourStackCore.sv
module fourStackCore
  import fsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int PC_W   = 16,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [4:0]        opcode,
  input  logic [1:0]        stackSel,
  input  logic [OFF_W-1:0]  offset,
  input  logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   pc,
  output logic [DATA_W-1:0] tos,
  output logic [3:0]        ovfErr,
  output logic [3:0]        unfErr
);
  strobe_t               stb;
  logic [NUM_STACKS-1:0] full;
  logic [NUM_STACKS-1:0] empty;

  fscControl #(.PC_W(PC_W), .OFF_W(OFF_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .opcode     (opcode),
    .stackSel   (stackSel),
    .offset     (offset),
    .target     (target),
    .tosZero    (tos == '0),
    .full       (full),
    .empty      (empty),
    .stb        (stb),
    .pc         (pc),
    .ovfErr     (ovfErr),
    .unfErr     (unfErr)
  );

  fscDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .tos   (tos),
    .full  (full),
    .empty (empty)
  );
endmodule

// File: rtl/fscCheck.sv
module fscCheck #(
  parameter int DATA_W = 16,
  parameter int PC_W   = 16,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrValid,
  input logic [4:0]        opcode,
  input logic [OFF_W-1:0]  offset,
  input logic [PC_W-1:0]   target,
  input logic [PC_W-1:0]   pc,
  input logic [DATA_W-1:0] tos,
  input logic [3:0]        ovfErr,
  input logic [3:0]        unfErr
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> ($stable(pc) && $stable(tos) && $stable(ovfErr) && $stable(unfErr))); // R12

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((ovfErr & $past(ovfErr)) == $past(ovfErr))); // R10

  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((unfErr & $past(unfErr)) == $past(unfErr))); // R11

  AST_ONE_NEW_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $onehot0({ovfErr ^ $past(ovfErr), unfErr ^ $past(unfErr)})); // R10

  AST_INC_TOS: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opcode == 5'd6) |=> (tos == DATA_W'($past(tos) + 1'b1))); // R6

  AST_JMP_PC: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opcode == 5'd12) |=>
      (pc == PC_W'($past(pc) + 1'b1 + {{(PC_W-OFF_W){$past(offset[OFF_W-1])}}, $past(offset)}))); // R9

  AST_CALL_PC: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opcode == 5'd13) |=> (pc == $past(target))); // R9

  AST_CALL_TOS: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opcode == 5'd13) |=> $stable(tos)); // R9
endmodule

bind fourStackCore fscCheck #(.DATA_W(DATA_W), .PC_W(PC_W), .OFF_W(OFF_W)) uCheck (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .opcode     (opcode),
  .offset     (offset),
  .target     (target),
  .pc         (pc),
  .tos        (tos),
  .ovfErr     (ovfErr),
  .unfErr     (unfErr)
);

// File: tb/tb_fourStackCore.sv
module tb_fourStackCore;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int PC_W   = 16;
  localparam int OFF_W  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              instrValid = 1'b0;
  logic [4:0]        opcode = '0;
  logic [1:0]        stackSel = '0;
  logic [OFF_W-1:0]  offset = '0;
  logic [PC_W-1:0]   target = '0;
  logic [PC_W-1:0]   pc;
  logic [DATA_W-1:0] tos;
  logic [3:0]        ovfErr, unfErr;

  always #4 clk = ~clk;

  fourStackCore #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PC_W(PC_W), .OFF_W(OFF_W)) dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .opcode(opcode),
    .stackSel(stackSel), .offset(offset), .target(target),
    .pc(pc), .tos(tos), .ovfErr(ovfErr), .unfErr(unfErr)
  );

  // behavioural reference
  logic [DATA_W-1:0] mStk [4][$];
  logic [DATA_W-1:0] mTos;
  logic [PC_W-1:0]   mPc;
  logic [3:0]        mOvf, mUnf;
  string             lastTag;
  int vectors = 0;
  int misses  = 0;

  task automatic compare(input string tag);
    vectors++;
    if (pc !== mPc || tos !== mTos || ovfErr !== mOvf || unfErr !== mUnf) begin
      misses++;
      $display("FAIL %s: pc=%h tos=%h ovf=%b unf=%b expected pc=%h tos=%h ovf=%b unf=%b",
               tag, pc, tos, ovfErr, unfErr, mPc, mTos, mOvf, mUnf);
    end
  endtask

  task automatic modelStep(input logic v, input logic [4:0] op, input logic [1:0] sel,
                           input logic [OFF_W-1:0] off, input logic [PC_W-1:0] tgt);
    int s;
    logic isRead;
    logic [DATA_W-1:0] a;
    logic [PC_W-1:0] rel;
    logic taken;
    if (!v) begin lastTag = "R12"; return; end
    s = (op == 5'd11) ? 0 : int'(sel);
    isRead = (op == 5'd2 || op == 5'd3 || op == 5'd4 || op == 5'd5 ||
              op == 5'd8 || op == 5'd10 || op == 5'd11);
    rel = mPc + 1 + {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
    if (op == 5'd1 && mStk[s].size() == DEPTH) begin
      mOvf[s] = 1'b1; mPc = mPc + 1; lastTag = "R10"; return;
    end
    if (isRead && mStk[s].size() == 0) begin
      mUnf[s] = 1'b1; mPc = mPc + 1; lastTag = "R11"; return;
    end
    a = isRead ? mStk[s][$] : '0;
    mPc = mPc + 1;
    case (op)
      5'd1:  begin mStk[s].push_back(mTos); lastTag = "R2"; end
      5'd2:  begin mTos = a; lastTag = "R3"; end
      5'd3:  begin void'(mStk[s].pop_back()); mTos = a; lastTag = "R4"; end
      5'd4:  begin void'(mStk[s].pop_back()); mTos = a + mTos; lastTag = "R5"; end
      5'd5:  begin void'(mStk[s].pop_back()); mTos = a - mTos; lastTag = "R5"; end
      5'd6:  begin mTos = mTos + 1; lastTag = "R6"; end
      5'd7:  begin mTos = mTos - 1; lastTag = "R6"; end
      5'd8:  begin void'(mStk[s].pop_back());
                   mTos = ($signed(a) > $signed(mTos)) ? '1 : '0; lastTag = "R7"; end
      5'd9:  begin mTos = ($signed(mTos) > 0) ? '1 : '0; lastTag = "R7"; end
      5'd10: begin void'(mStk[s].pop_back());
                   mTos = ($signed(a) <= $signed(mTos)) ? '1 : '0; lastTag = "R7"; end
      5'd11: begin taken = (mTos == 0); void'(mStk[0].pop_back()); mTos = a;
                   if (taken) mPc = rel; lastTag = "R8"; end
      5'd12: begin mPc = rel; lastTag = "R9"; end
      5'd13: begin mPc = tgt; lastTag = "R9"; end
      default: lastTag = "R13";
    endcase
  endtask

  task automatic step(input logic v, input logic [4:0] op, input logic [1:0] sel,
                      input logic [OFF_W-1:0] off, input logic [PC_W-1:0] tgt);
    instrValid = v; opcode = op; stackSel = sel; offset = off; target = tgt;
    @(posedge clk);
    modelStep(v, op, sel, off, tgt);
    @(negedge clk);
    compare(lastTag);
  endtask

  task automatic run(input logic [4:0] op, input logic [1:0] sel);
    step(1'b1, op, sel, '0, '0);
  endtask

  initial begin
    #(8 * 150000);
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    mTos = '0; mPc = '0; mOvf = '0; mUnf = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compare("R1");                       // reset state

    // R2/R3/R4: dup, over, drop on several stacks
    run(5'd6, 2'd0); run(5'd6, 2'd0);   // tos = 2 (R6)
    run(5'd1, 2'd1);                     // push 2 onto B (R2)
    run(5'd7, 2'd3);                     // tos = 1
    run(5'd2, 2'd1);                     // over B -> 2 (R3)
    run(5'd7, 2'd0); run(5'd7, 2'd0);   // tos = 0
    run(5'd3, 2'd1);                     // drop B -> 2 (R4)
    // R5: add/sub with wrap
    run(5'd7, 2'd0); run(5'd7, 2'd0); run(5'd7, 2'd0); // tos = -1
    run(5'd1, 2'd2); run(5'd6, 2'd0); run(5'd6, 2'd0); // C:[ffff] tos=1
    run(5'd4, 2'd2);                     // ffff + 1 = 0 (R5 wrap)
    run(5'd1, 2'd3); run(5'd6, 2'd0); run(5'd5, 2'd3); // 0 - 1 = ffff (R5)
    // R7: signed compares at the sign boundary
    run(5'd9, 2'd0);                     // gtz(-1) = 0
    run(5'd1, 2'd0); run(5'd6, 2'd0);   // A:[0] tos=1
    run(5'd8, 2'd0);                     // 0 > 1 false -> 0
    run(5'd1, 2'd1); run(5'd7, 2'd0);   // B:[0] tos=ffff
    run(5'd10, 2'd1);                    // 0 <= -1 false -> 0
    run(5'd1, 2'd1); run(5'd10, 2'd1);  // 0 <= 0 true -> ffff
    run(5'd9, 2'd0);                     // gtz(-1) -> 0
    run(5'd6, 2'd0); run(5'd9, 2'd0);   // gtz(1) -> ffff
    // R8: jz taken (tos 0) with negative offset, and not taken
    run(5'd1, 2'd0);                     // A:[ffff]
    run(5'd6, 2'd0);                     // tos = 0
    run(5'd1, 2'd0);                     // A:[ffff,0]
    step(1'b1, 5'd11, 2'd3, 5'b10000, '0); // taken, offset -16, tos <- 0
    run(5'd6, 2'd0);                     // tos 1
    step(1'b1, 5'd11, 2'd2, 5'd5, '0);   // not taken, tos <- ffff
    // R9: jmp and call
    step(1'b1, 5'd12, 2'd0, 5'd15, '0);
    step(1'b1, 5'd12, 2'd0, 5'b11111, '0);
    step(1'b1, 5'd13, 2'd1, 5'd3, 16'hbeef);
    // R12: idle cycles with busy-looking inputs
    step(1'b0, 5'd1, 2'd0, 5'd3, 16'h1234);
    step(1'b0, 5'd13, 2'd2, 5'd3, 16'h1234);
    // R13: unlisted opcodes
    run(5'd0, 2'd1); run(5'd14, 2'd1); run(5'd31, 2'd3);
    // R11: underflow on empty D, on jz with A empty, then state unchanged
    run(5'd3, 2'd3);
    run(5'd11, 2'd0);
    run(5'd2, 2'd1);
    // R10: overflow on A after DEPTH pushes; tos and contents preserved
    for (int i = 0; i < DEPTH + 2; i++) begin
      run(5'd1, 2'd0); run(5'd6, 2'd0);
    end
    for (int i = 0; i < DEPTH + 1; i++) run(5'd3, 2'd0);

    // random stream
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] op;
      op = ($urandom_range(0, 19) == 0) ? 5'($urandom_range(14, 31))
                                        : 5'($urandom_range(0, 13));
      step($urandom_range(0, 9) != 0, op, 2'($urandom_range(0, 3)),
           5'($urandom), 16'($urandom));
    end

    // R1 again: mid-run reset
    rstN = 1'b0;
    @(posedge clk);
    mTos = '0; mPc = '0; mOvf = '0; mUnf = '0;
    for (int s = 0; s < 4; s++) mStk[s].delete();
    @(negedge clk);
    rstN = 1'b1;
    compare("R1");
    run(5'd2, 2'd2);                     // stacks empty after reset (R1/R11)

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule